// File: doc/BRIEF.md
# Two-Line Programmable-Depth Glitch Filter

This block cleans the clock and data lines of a two-wire serial bus before they reach the bus state machines. Each line has its own lane. The lane brings the pin into the system clock domain and keeps a four-deep history of samples. A new level is accepted only after it has been seen on enough consecutive samples. Samples are taken once per falling edge of a separate, slower filter clock. That clock is brought into the system clock domain and turned into a one-cycle sampling strobe.

A 2-bit depth select sets how many history stages must agree with the present sample. While samples disagree, the lane keeps the last accepted level. A filter enable of 0 turns the filtering off: the synchronised pin then drives the output directly. After reset, every flop that carries line state reads 1, which is the idle level of the bus. This means a false bus event cannot appear as reset is released.

Top module: `bus_glitch_filter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both outputs read 1, whatever the pins are doing.
- R2: The depth select chooses N compared stages: 0 gives N=1, 1 gives N=2, 2 gives N=3 and 3 gives N=4. A filtered output takes a new level only at a sampling strobe, and only when the present sample equals all N most recent stored samples.
- R3: With filtering on, a pulse on a pin shorter than 4N-1 system clock cycles never reaches the output. In the bench, the filter clock period is 4 system clock cycles.
- R4: With filtering on, a pin level held steady reaches the output after more than 4N system cycles and within 4N+8 system cycles. That window is N to N+2 filter-clock periods.
- R5: While the compared samples disagree, and between strobes, the output keeps its last accepted value.
- R6: With the filter enable at 0, the output equals the pin level delayed by exactly 3 system clock cycles: two synchroniser flops and one output flop. This holds for single-cycle pulses as well.
- R7: A change of the depth select applies from the next strobe. All four stages shift at all times, so a switch to a larger N right after a long steady level needs no refill time.
- R8: The two lanes are independent: activity on one pin never moves the other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fclk_i | input | 1 | Filter sampling clock; its falling edges set the sample points |
| filt_en_i | input | 1 | 1 = filter the pins, 0 = pass them through after synchronisation |
| depth_sel_i | input | 2 | Number of compared stages minus one |
| scl_pin_i | input | 1 | Raw serial clock line level |
| sda_pin_i | input | 1 | Raw serial data line level |
| scl_o | output | 1 | Cleaned serial clock level |
| sda_o | output | 1 | Cleaned serial data level |

## Verification
Two things can happen in the same cycle: a change of the depth select and a change of the line level. The bench provokes this by changing both on the same clock. It holds the line at 0 for a long time with one compared stage, then raises the pin and selects four stages at once. It then checks that the output stays at 0 for the whole four-stage window and rises no later than the four-stage bound. This shows that the new depth was used from the first strobe and that the history stages were already valid.

// File: rtl/glf_pkg.sv
package glf_pkg;

    localparam int unsigned GLF_MAX_STAGES = 4;
    localparam int unsigned GLF_SEL_W      = $clog2(GLF_MAX_STAGES);
    localparam int unsigned GLF_LANES      = 2;

    typedef logic [GLF_SEL_W-1:0]      depth_sel_t;
    typedef logic [GLF_MAX_STAGES-1:0] stage_vec_t;

    typedef enum logic {
        LANE_SCL = 1'b0,
        LANE_SDA = 1'b1
    } lane_e;

    typedef struct packed {
        logic       strobe;
        logic       filt_en;
        depth_sel_t depth;
    } lane_ctl_t;

    // Stage i takes part in the comparison when i < N, where N = sel + 1
    function automatic stage_vec_t depth_mask(depth_sel_t sel);
        stage_vec_t m;
        for (int i = 0; i < GLF_MAX_STAGES; i++) begin
            m[i] = (i <= int'(sel));
        end
        return m;
    endfunction

endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
    parameter int unsigned    W         = 1,
    parameter int unsigned    STAGES    = 2,
    parameter logic [W-1:0]   RESET_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RESET_VAL;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/glf_fall_detect.sv
module glf_fall_detect (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic strobe_o
);

    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_i;
    end

    assign strobe_o = prev_q & ~lvl_i;

    // R2
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/glf_lane.sv
module glf_lane
    import glf_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  lane_ctl_t ctl_i,
    input  logic      din_i,
    output logic      dout_o
);

    stage_vec_t chain_q;
    stage_vec_t agree;
    stage_vec_t mask;
    logic       match;
    logic       dout_q;

    // History keeps shifting whatever the selected depth (R7)
    always_ff @(posedge clk_i) begin
        if (rst_i)             chain_q <= '1;
        else if (ctl_i.strobe) chain_q <= {chain_q[GLF_MAX_STAGES-2:0], din_i};
    end

    for (genvar s = 0; s < GLF_MAX_STAGES; s++) begin : g_cmp
        assign agree[s] = (chain_q[s] == din_i);
    end

    assign mask  = depth_mask(ctl_i.depth);
    assign match = &(agree | ~mask);

    always_ff @(posedge clk_i) begin
        if (rst_i)                        dout_q <= 1'b1;
        else if (!ctl_i.filt_en)          dout_q <= din_i;
        else if (ctl_i.strobe && match)   dout_q <= din_i;
    end

    assign dout_o = dout_q;

    // R5
    hold_between_strobes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_i.filt_en && !ctl_i.strobe) |=> $stable(dout_q));

    // R5
    hold_on_mismatch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_i.filt_en && ctl_i.strobe && (agree[0] == 1'b0)) |=> $stable(dout_q));

    // R2
    accept_matches_newest_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_i.filt_en && ctl_i.strobe) |=> (dout_q == $past(dout_q)) || (dout_q == chain_q[0]));

    // R6
    bypass_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl_i.filt_en |=> dout_q == $past(din_i));

endmodule

// File: rtl/bus_glitch_filter.sv
module bus_glitch_filter
    import glf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 fclk_i,
    input  logic                 filt_en_i,
    input  logic [GLF_SEL_W-1:0] depth_sel_i,
    input  logic                 scl_pin_i,
    input  logic                 sda_pin_i,
    output logic                 scl_o,
    output logic                 sda_o
);

    logic [GLF_LANES-1:0] pin_raw;
    logic [GLF_LANES-1:0] pin_s;
    logic [GLF_LANES-1:0] lane_out;
    logic                 fclk_s;
    logic                 strobe;
    lane_ctl_t            ctl;

    assign pin_raw[LANE_SCL] = scl_pin_i;
    assign pin_raw[LANE_SDA] = sda_pin_i;

    glf_sync #(.W(GLF_LANES), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_pin_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_raw),
        .q_o   (pin_s)
    );

    glf_sync #(.W(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_fclk_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (fclk_i),
        .q_o   (fclk_s)
    );

    glf_fall_detect u_fall (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .lvl_i    (fclk_s),
        .strobe_o (strobe)
    );

    assign ctl = '{strobe: strobe, filt_en: filt_en_i, depth: depth_sel_i};

    for (genvar g = 0; g < GLF_LANES; g++) begin : g_lane
        glf_lane u_lane (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .ctl_i  (ctl),
            .din_i  (pin_s[g]),
            .dout_o (lane_out[g])
        );
    end

    assign scl_o = lane_out[LANE_SCL];
    assign sda_o = lane_out[LANE_SDA];

    // R1
    reset_idle_chk: assert property (@(posedge clk_i)
        rst_i |=> (scl_o && sda_o));

endmodule

// File: tb/bus_glitch_filter_bench.sv
module bus_glitch_filter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic [1:0] sel = 2'd0;
    logic [1:0] pin = 2'b11;
    logic [1:0] div = 2'd0;
    logic       fclk;
    logic       scl_o, sda_o;
    logic [1:0] outv;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    // filter clock period = 4 system cycles
    always @(negedge clk) div <= div + 2'd1;
    assign fclk = div[1];
    assign outv = {sda_o, scl_o};

    bus_glitch_filter u_bus_glitch_filter (
        .clk_i       (clk),
        .rst_i       (rst),
        .fclk_i      (fclk),
        .filt_en_i   (en),
        .depth_sel_i (sel),
        .scl_pin_i   (pin[0]),
        .sda_pin_i   (pin[1]),
        .scl_o       (scl_o),
        .sda_o       (sda_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle(input logic [1:0] lvl);
        pin = lvl;
        repeat (40) tick();
        chk("R4 settle lane0", outv[0], lvl[0]);
        chk("R4 settle lane1", outv[1], lvl[1]);
    endtask

    task automatic prop_test(input int lane, input int n, input logic v);
        logic [1:0] base;
        logic       other;
        int         oth;
        oth   = 1 - lane;
        other = lane[0];
        base  = 2'b00;
        base[lane] = ~v;
        base[oth]  = other;
        en  = 1'b1;
        sel = 2'(n - 1);
        settle(base);
        pin[lane] = v;
        for (int c = 1; c <= 4*n + 8; c++) begin
            tick();
            if (c <= 4*n) chk("R4 too early / R2", outv[lane], ~v);
            chk("R8 other lane still", outv[oth], other);
        end
        chk("R4 level arrived", outv[lane], v);
    endtask

    task automatic glitch_test(input int lane, input int n, input logic v);
        logic [1:0] base;
        int         oth;
        oth = 1 - lane;
        base = 2'b00;
        base[lane] = ~v;
        base[oth]  = 1'b1;
        en  = 1'b1;
        sel = 2'(n - 1);
        settle(base);
        pin[lane] = v;
        for (int c = 1; c <= 4*n - 1; c++) begin
            tick();
            chk("R3 pulse held off / R5", outv[lane], ~v);
        end
        pin[lane] = ~v;
        for (int c = 0; c < 40; c++) begin
            tick();
            chk("R3 pulse suppressed / R5", outv[lane], ~v);
            chk("R8 other lane still", outv[oth], 1'b1);
        end
    endtask

    task automatic bypass_test(input int lane, input logic v);
        en = 1'b1;
        sel = 2'd0;
        settle(lane == 0 ? {1'b1, ~v} : {~v, 1'b1});
        en = 1'b0;
        repeat (4) tick();
        pin[lane] = v;
        tick();
        pin[lane] = ~v;
        chk("R6 bypass c1", outv[lane], ~v);
        tick();
        chk("R6 bypass c2", outv[lane], ~v);
        tick();
        chk("R6 bypass c3 pulse", outv[lane], v);
        tick();
        chk("R6 bypass c4 back", outv[lane], ~v);
        chk("R8 bypass other lane", outv[1-lane], 1'b1);
        en = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle high during reset even with pins low
        pin = 2'b00;
        repeat (6) tick();
        chk("R1 reset scl", outv[0], 1'b1);
        chk("R1 reset sda", outv[1], 1'b1);
        pin = 2'b11;
        tick();
        rst = 1'b0;
        tick();
        chk("R1 after release scl", outv[0], 1'b1);
        chk("R1 after release sda", outv[1], 1'b1);

        for (int n = 1; n <= 4; n++) begin
            for (int lane = 0; lane < 2; lane++) begin
                prop_test(lane, n, 1'b0);
                prop_test(lane, n, 1'b1);
                glitch_test(lane, n, 1'b0);
                glitch_test(lane, n, 1'b1);
            end
        end

        for (int lane = 0; lane < 2; lane++) begin
            bypass_test(lane, 1'b0);
            bypass_test(lane, 1'b1);
        end

        // R7: depth change and level change in the same cycle
        en  = 1'b1;
        sel = 2'd0;
        settle(2'b10);
        sel = 2'd3;
        pin[0] = 1'b1;
        for (int c = 1; c <= 24; c++) begin
            tick();
            if (c <= 16) chk("R7 new depth applied at once", outv[0], 1'b0);
        end
        chk("R7 level arrived under new depth", outv[0], 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule